// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight level-sensitive interrupt requests, removes the masked ones and selects the lowest-numbered remaining input as the winner. A winner is forwarded as an interrupt to the processor only when no input of equal or higher priority is already being serviced. The processor answers with two acknowledge pulses on a shared line. On the first pulse the controller marks the winner as in service. On the second pulse it drives an 8-bit type number, built from a programmed base and the winning index.

Several controllers can be chained. One controller is the master, and up to eight slaves feed its request inputs. While the first acknowledge pulse is high, the master places the 3-bit index of the winning input on a shared cascade bus if a slave hangs on that input. Every slave compares that code with its own programmed identity when the pulse ends. Only the matching slave drives the type number on the second pulse, and the master stays silent. Software programs the controller through a small command port, which sets the base vector, the mask, the role and identity, and the map of cascaded inputs, and which issues a non-specific end-of-interrupt.

Top module: `pic_cascade_ctrl`

## Requirements
- R1: After reset the interrupt output is low, neither the cascade bus nor the vector bus is driven, no input is masked, nothing is in service, the role is master with no cascaded inputs, and the base is zero.
- R2: Among the unmasked active requests, the one with the lowest index wins, and its index forms the low three bits of the type number.
- R3: The interrupt output goes high one clock after the winning request exists, provided that no in-service bit at an index less than or equal to the winner is set. Otherwise it stays low.
- R4: A mask bit at 1 removes the input with the same index from the priority decision.
- R5: A master drives cas_oe high and cas_out equal to the winner index during the first acknowledge pulse only if the slave-map bit of that index is 1. A slave never drives the cascade bus.
- R6: A master whose winner has its slave-map bit set does not drive the vector bus on the second pulse. A master whose winner has no slave does drive it.
- R7: The selected device drives vec_oe high and vec_out = {base[7:3], index} from the clock after the second pulse rises until the clock after it falls. vec_out is zero whenever vec_oe is low.
- R8: A slave drives the vector on the second pulse, and sets the in-service bit of its winner, only if cas_in equals its identity at the clock where the first pulse is seen low again.
- R9: A master sets the in-service bit of its winner at the clock where it detects the rising edge of the first acknowledge pulse.
- R10: An end-of-interrupt command clears only the lowest-indexed set in-service bit.
- R11: If no request qualifies when the first pulse rises, the type number uses index 7, no in-service bit is set and the cascade bus stays undriven.
- R12: Command codes on cfg_sel: 0 writes the base (only cfg_data[7:3] is kept), 1 writes the mask, 2 writes the role (cfg_data[7]=1 selects slave, cfg_data[2:0] is the identity), 3 writes the slave map, and 4 issues an end-of-interrupt. Codes 5 to 7 have no effect.
- R13: Requests are level-sensitive. When a request is withdrawn, the interrupt output falls one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Level-sensitive request inputs, index 0 highest |
| cfg_wr | input | 1 | Command strobe, one cycle |
| cfg_sel | input | 3 | Command code |
| cfg_data | input | 8 | Command data |
| ack | input | 1 | Acknowledge line, active high, two pulses per sequence |
| cas_in | input | 3 | Cascade code seen on the shared bus |
| int_out | output | 1 | Interrupt request to the processor or master |
| cas_out | output | 3 | Cascade code driven by a master |
| cas_oe | output | 1 | Cascade bus drive enable |
| vec_out | output | 8 | Type number |
| vec_oe | output | 1 | Vector bus drive enable |

## Verification
On every cycle, the assertions check that the cascade and vector drivers are never on together and that each stays steady while it is driving. They also check that the vector is only driven right after the acknowledge line was high, that a slave never drives the cascade bus, and that nothing is forwarded while input 0 is in service. Whether the chosen winner is correct, how end-of-interrupt reorders service, how masking acts, and how a slave matches its identity all depend on the history of commands and requests. These can only be shown by the bench's scenarios, which run against a behavioural model compared on every clock.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NIR = 8;
  localparam int IW  = $clog2(NIR);
  localparam int VW  = 8;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_P1   = 2'd1,
    ACK_GAP  = 2'd2,
    ACK_P2   = 2'd3
  } ack_st_e;

  localparam logic [2:0] CMD_BASE = 3'd0;
  localparam logic [2:0] CMD_MASK = 3'd1;
  localparam logic [2:0] CMD_ROLE = 3'd2;
  localparam logic [2:0] CMD_SMAP = 3'd3;
  localparam logic [2:0] CMD_EOI  = 3'd4;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N_IR = pic_pkg::NIR,
  localparam int IW  = $clog2(N_IR)
) (
  input  logic [N_IR-1:0] elig,
  input  logic [N_IR-1:0] isr,
  output logic [IW-1:0]   win,
  output logic            req_ok,
  output logic [IW-1:0]   isr_top,
  output logic            isr_any
);
  logic [N_IR-1:0] below_req;
  logic [N_IR-1:0] isr_upto;
  logic [N_IR-1:0] grant;
  logic [N_IR-1:0] isr_first;

  for (genvar i = 0; i < N_IR; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign below_req[i] = 1'b0;
      assign isr_upto[i]  = isr[i];
      assign isr_first[i] = isr[i];
    end else begin : g_rest
      assign below_req[i] = below_req[i-1] | elig[i-1];
      assign isr_upto[i]  = isr_upto[i-1] | isr[i];
      assign isr_first[i] = isr[i] & ~isr_upto[i-1];
    end
    assign grant[i] = elig[i] & ~below_req[i];
  end

  always_comb begin
    win     = '0;
    isr_top = '0;
    for (int i = 0; i < N_IR; i++) begin
      if (grant[i])     win     = win | IW'(i);
      if (isr_first[i]) isr_top = isr_top | IW'(i);
    end
  end

  assign req_ok  = (|grant) & ~(|(grant & isr_upto));
  assign isr_any = isr_upto[N_IR-1];
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs #(
  parameter int N_IR = pic_pkg::NIR,
  parameter int VW   = pic_pkg::VW,
  localparam int IW  = $clog2(N_IR),
  localparam int BW  = VW - IW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_sel,
  input  logic [VW-1:0]   cfg_data,
  output logic [BW-1:0]   base_q,
  output logic [N_IR-1:0] mask_q,
  output logic            slave_q,
  output logic [IW-1:0]   id_q,
  output logic [N_IR-1:0] smap_q,
  output logic            eoi
);
  import pic_pkg::*;

  logic [BW-1:0]   base_d;
  logic [N_IR-1:0] mask_d;
  logic            slave_d;
  logic [IW-1:0]   id_d;
  logic [N_IR-1:0] smap_d;
  logic            upd;

  always_comb begin
    base_d  = base_q;
    mask_d  = mask_q;
    slave_d = slave_q;
    id_d    = id_q;
    smap_d  = smap_q;
    upd     = 1'b0;
    eoi     = 1'b0;
    if (cfg_wr) begin
      case (cfg_sel)
        CMD_BASE: begin base_d = cfg_data[VW-1:IW]; upd = 1'b1; end
        CMD_MASK: begin mask_d = cfg_data[N_IR-1:0]; upd = 1'b1; end
        CMD_ROLE: begin
          slave_d = cfg_data[VW-1];
          id_d    = cfg_data[IW-1:0];
          upd     = 1'b1;
        end
        CMD_SMAP: begin smap_d = cfg_data[N_IR-1:0]; upd = 1'b1; end
        CMD_EOI:  eoi = 1'b1;
        default:  upd = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      mask_q  <= '0;
      slave_q <= 1'b0;
      id_q    <= '0;
      smap_q  <= '0;
    end else if (upd) begin
      base_q  <= base_d;
      mask_q  <= mask_d;
      slave_q <= slave_d;
      id_q    <= id_d;
      smap_q  <= smap_d;
    end
  end
endmodule

// File: rtl/pic_isr.sv
module pic_isr #(
  parameter int N_IR = pic_pkg::NIR,
  localparam int IW  = $clog2(N_IR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eoi,
  input  logic            isr_any,
  input  logic [IW-1:0]   isr_top,
  input  logic            set_en,
  input  logic [IW-1:0]   set_idx,
  output logic [N_IR-1:0] isr_q
);
  localparam logic [N_IR-1:0] ONE = N_IR'(1);

  logic [N_IR-1:0] isr_d;
  logic            isr_en;

  always_comb begin
    isr_d = isr_q;
    if (eoi && isr_any) isr_d = isr_d & ~(ONE << isr_top);
    if (set_en)         isr_d = isr_d | (ONE << set_idx);
    isr_en = (eoi && isr_any) || set_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= '0;
    else if (isr_en) isr_q <= isr_d;
  end
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq #(
  parameter int N_IR = pic_pkg::NIR,
  localparam int IW  = $clog2(N_IR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack,
  input  logic [IW-1:0]   cas_in,
  input  logic            slave,
  input  logic [IW-1:0]   id,
  input  logic [N_IR-1:0] smap,
  input  logic            req_ok,
  input  logic [IW-1:0]   win,
  output logic            set_en,
  output logic [IW-1:0]   set_idx,
  output logic [IW-1:0]   idx_q,
  output logic            cas_oe,
  output logic            vec_oe
);
  import pic_pkg::*;

  ack_st_e       st_q, st_d;
  logic          ack_q;
  logic          hit_q, hit_d;
  logic          sel_q, sel_d;
  logic [IW-1:0] idx_d;
  logic          rise, fall, match;

  assign rise  = ack & ~ack_q;
  assign fall  = ~ack & ack_q;
  assign match = (cas_in == id);

  always_comb begin
    st_d    = st_q;
    hit_d   = hit_q;
    sel_d   = sel_q;
    idx_d   = idx_q;
    set_en  = 1'b0;
    set_idx = idx_q;
    case (st_q)
      ACK_IDLE: if (rise) begin
        st_d  = ACK_P1;
        hit_d = req_ok;
        idx_d = req_ok ? win : '1;
        if (slave) begin
          sel_d = 1'b0;
        end else begin
          sel_d   = ~(req_ok & smap[win]);
          set_en  = req_ok;
          set_idx = win;
        end
      end
      ACK_P1: if (fall) begin
        st_d = ACK_GAP;
        if (slave) begin
          sel_d   = match;
          set_en  = hit_q & match;
          set_idx = idx_q;
        end
      end
      ACK_GAP: if (rise) st_d = ACK_P2;
      ACK_P2:  if (fall) st_d = ACK_IDLE;
      default: st_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ACK_IDLE;
      ack_q <= 1'b0;
      hit_q <= 1'b0;
      sel_q <= 1'b0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack;
      hit_q <= hit_d;
      sel_q <= sel_d;
      idx_q <= idx_d;
    end
  end

  assign cas_oe = (st_q == ACK_P1) & ~slave & hit_q & smap[idx_q];
  assign vec_oe = (st_q == ACK_P2) & sel_q;
endmodule

// File: rtl/pic_cascade_ctrl.sv
module pic_cascade_ctrl #(
  parameter int N_IR = pic_pkg::NIR,
  parameter int VW   = pic_pkg::VW,
  localparam int IW  = $clog2(N_IR),
  localparam int BW  = VW - IW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IR-1:0] irq_in,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_sel,
  input  logic [VW-1:0]   cfg_data,
  input  logic            ack,
  input  logic [IW-1:0]   cas_in,
  output logic            int_out,
  output logic [IW-1:0]   cas_out,
  output logic            cas_oe,
  output logic [VW-1:0]   vec_out,
  output logic            vec_oe
);
  logic [BW-1:0]   base_q;
  logic [N_IR-1:0] mask_q;
  logic            role_slave;
  logic [IW-1:0]   id_q;
  logic [N_IR-1:0] smap_q;
  logic            eoi;
  logic [N_IR-1:0] isr_q;
  logic [IW-1:0]   win, isr_top, set_idx, idx_q;
  logic            req_ok, isr_any, set_en;
  logic            int_q, int_d;

  pic_cfg_regs #(.N_IR(N_IR), .VW(VW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .base_q(base_q), .mask_q(mask_q),
    .slave_q(role_slave), .id_q(id_q), .smap_q(smap_q), .eoi(eoi)
  );

  pic_prio #(.N_IR(N_IR)) u_prio (
    .elig(irq_in & ~mask_q), .isr(isr_q), .win(win), .req_ok(req_ok),
    .isr_top(isr_top), .isr_any(isr_any)
  );

  pic_isr #(.N_IR(N_IR)) u_isr (
    .clk(clk), .rst_n(rst_n), .eoi(eoi), .isr_any(isr_any),
    .isr_top(isr_top), .set_en(set_en), .set_idx(set_idx), .isr_q(isr_q)
  );

  pic_ack_seq #(.N_IR(N_IR)) u_seq (
    .clk(clk), .rst_n(rst_n), .ack(ack), .cas_in(cas_in),
    .slave(role_slave), .id(id_q), .smap(smap_q), .req_ok(req_ok),
    .win(win), .set_en(set_en), .set_idx(set_idx), .idx_q(idx_q),
    .cas_oe(cas_oe), .vec_oe(vec_oe)
  );

  assign int_d = req_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_q <= 1'b0;
    else        int_q <= int_d;
  end

  assign int_out = int_q;
  assign cas_out = cas_oe ? idx_q : '0;
  assign vec_out = vec_oe ? {base_q, idx_q} : '0;
endmodule

// File: rtl/pic_cascade_ctrl_chk.sv
module pic_cascade_ctrl_chk #(
  parameter int N_IR = pic_pkg::NIR,
  parameter int VW   = pic_pkg::VW,
  localparam int IW  = $clog2(N_IR)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            int_out,
  input logic            cas_oe,
  input logic [IW-1:0]   cas_out,
  input logic            vec_oe,
  input logic [VW-1:0]   vec_out,
  input logic [N_IR-1:0] isr_q,
  input logic            role_slave
);
  AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(cas_oe && vec_oe)); // R6
  AST_CAS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    cas_oe && $past(cas_oe) |-> $stable(cas_out)); // R5
  AST_SLAVE_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    role_slave |-> !cas_oe); // R5
  AST_VEC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe && $past(vec_oe) |-> $stable(vec_out)); // R7
  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> $past(ack)); // R7
  AST_TOP_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    isr_q[0] |=> !int_out); // R3
endmodule

bind pic_cascade_ctrl pic_cascade_ctrl_chk #(.N_IR(N_IR), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .int_out(int_out), .cas_oe(cas_oe),
  .cas_out(cas_out), .vec_oe(vec_oe), .vec_out(vec_out), .isr_q(isr_q),
  .role_slave(role_slave)
);

// File: tb/pic_cascade_ctrl_test.sv
`timescale 1ns/1ps
module pic_cascade_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic       ack = 1'b0;
  logic [2:0] cas_in = '0;
  logic       int_out, cas_oe, vec_oe;
  logic [2:0] cas_out;
  logic [7:0] vec_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pic_cascade_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .ack(ack), .cas_in(cas_in),
    .int_out(int_out), .cas_out(cas_out), .cas_oe(cas_oe),
    .vec_out(vec_out), .vec_oe(vec_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [4:0] m_base;
  logic [7:0] m_mask, m_smap, m_isr, el;
  logic       m_slave, m_int, m_ackq, m_hit, m_sel;
  logic [2:0] m_id, m_idx;
  int         m_st, w, t, n_st;
  bit         rv, rise, fall;
  logic [7:0] n_isr;
  logic       n_hit, n_sel;
  logic [2:0] n_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = '0; m_mask = '0; m_smap = '0; m_isr = '0; m_slave = 0;
      m_int = 0; m_ackq = 0; m_hit = 0; m_sel = 0; m_id = '0; m_idx = '0;
      m_st = 0;
    end else begin
      el = irq_in & ~m_mask;
      w = -1;
      for (int i = 7; i >= 0; i--) if (el[i]) w = i;
      rv = (w >= 0);
      if (rv) for (int j = 0; j <= w; j++) if (m_isr[j]) rv = 0;
      t = -1;
      for (int i = 7; i >= 0; i--) if (m_isr[i]) t = i;
      rise = ack && !m_ackq;
      fall = !ack && m_ackq;
      n_isr = m_isr;
      if (cfg_wr && cfg_sel == 3'd4 && t >= 0) n_isr[t] = 1'b0;
      n_st = m_st; n_hit = m_hit; n_sel = m_sel; n_idx = m_idx;
      if (m_st == 0 && rise) begin
        n_st = 1; n_hit = rv; n_idx = rv ? 3'(w) : 3'd7;
        if (m_slave) n_sel = 0;
        else begin
          n_sel = !(rv && m_smap[w]);
          if (rv) n_isr[w] = 1'b1;
        end
      end else if (m_st == 1 && fall) begin
        n_st = 2;
        if (m_slave) begin
          n_sel = (cas_in == m_id);
          if (m_hit && cas_in == m_id) n_isr[m_idx] = 1'b1;
        end
      end else if (m_st == 2 && rise) n_st = 3;
      else if (m_st == 3 && fall) n_st = 0;
      if (cfg_wr) begin
        if (cfg_sel == 3'd0) m_base = cfg_data[7:3];
        if (cfg_sel == 3'd1) m_mask = cfg_data;
        if (cfg_sel == 3'd2) begin m_slave = cfg_data[7]; m_id = cfg_data[2:0]; end
        if (cfg_sel == 3'd3) m_smap = cfg_data;
      end
      m_isr = n_isr; m_st = n_st; m_hit = n_hit; m_sel = n_sel; m_idx = n_idx;
      m_int = rv; m_ackq = ack;
      #2;
      begin
        logic e_coe, e_voe;
        e_coe = (m_st == 1) && !m_slave && m_hit && m_smap[m_idx];
        e_voe = (m_st == 3) && m_sel;
        chk("R3 int_out vs model", int_out, m_int);
        chk("R5 cas_oe vs model", cas_oe, e_coe);
        chk("R5 cas_out vs model", cas_out, e_coe ? m_idx : 0);
        chk("R7 vec_oe vs model", vec_oe, e_voe);
        chk("R7 vec_out vs model", vec_out, e_voe ? {m_base, m_idx} : 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = s; cfg_data = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_seq(input logic [2:0] code, output logic c_oe,
                         output logic [2:0] c_val, output logic v_oe,
                         output logic [7:0] v_val);
    @(negedge clk); ack = 1; cas_in = code;
    @(negedge clk); c_oe = cas_oe; c_val = cas_out;
    @(negedge clk); ack = 0;
    idle(2);
    ack = 1;
    @(negedge clk); v_oe = vec_oe; v_val = vec_out;
    @(negedge clk); ack = 0;
    idle(2);
  endtask

  logic       coe, voe;
  logic [2:0] cval;
  logic [7:0] vval;

  initial begin
    idle(3);
    chk("R1 int_out at reset", int_out, 0);
    chk("R1 cas_oe at reset", cas_oe, 0);
    chk("R1 vec_oe at reset", vec_oe, 0);
    rst_n = 1;
    idle(2);

    wr(3'd0, 8'h45);  // R12 low base bits dropped
    irq_in = 8'h24; idle(2);
    chk("R2 winner raises int", int_out, 1);
    ack_seq(3'd0, coe, cval, voe, vval);
    chk("R11 no cascade when no slave", coe, 0);
    chk("R6 master drives vector", voe, 1);
    chk("R2 R12 vector index 2 base 0x40", vval, 8'h42);
    chk("R3 lower priority blocked by isr", int_out, 0);
    irq_in = 8'h26; idle(2);
    chk("R3 higher priority passes", int_out, 1);
    ack_seq(3'd0, coe, cval, voe, vval);
    chk("R9 second vector index 1", vval, 8'h41);
    chk("R9 isr set blocks", int_out, 0);
    wr(3'd4, 8'h00); idle(1);
    chk("R10 eoi frees index 1", int_out, 1);
    irq_in = 8'h24; idle(2);
    chk("R13 withdrawn request drops int", int_out, 0);
    wr(3'd4, 8'h00); idle(1);
    chk("R10 eoi then frees index 2", int_out, 1);
    irq_in = 8'h00; idle(2);
    chk("R13 int low without requests", int_out, 0);

    wr(3'd1, 8'h04);
    irq_in = 8'h04; idle(2);
    chk("R4 masked input ignored", int_out, 0);
    irq_in = 8'h0C; idle(2);
    ack_seq(3'd0, coe, cval, voe, vval);
    chk("R4 next unmasked wins", vval, 8'h43);
    wr(3'd4, 8'h00); irq_in = 8'h00; wr(3'd1, 8'h00);

    ack_seq(3'd0, coe, cval, voe, vval);
    chk("R11 spurious cas_oe", coe, 0);
    chk("R11 spurious vector index 7", vval, 8'h47);
    irq_in = 8'h80; idle(2);
    chk("R11 spurious sets no isr", int_out, 1);
    irq_in = 8'h00; idle(2);

    wr(3'd3, 8'h10);
    irq_in = 8'h10; idle(2);
    ack_seq(3'd0, coe, cval, voe, vval);
    chk("R5 master drives cascade", coe, 1);
    chk("R5 cascade code 4", cval, 3'd4);
    chk("R6 master silent on vector", voe, 0);
    wr(3'd4, 8'h00); irq_in = 8'h00; idle(2);

    wr(3'd2, 8'h83);
    irq_in = 8'h01; idle(2);
    chk("R8 slave raises int", int_out, 1);
    ack_seq(3'd3, coe, cval, voe, vval);
    chk("R5 slave never drives cascade", coe, 0);
    chk("R8 matching slave drives vector", voe, 1);
    chk("R8 slave vector value", vval, 8'h40);
    chk("R8 matching slave sets isr", int_out, 0);
    wr(3'd4, 8'h00); idle(2);
    ack_seq(3'd5, coe, cval, voe, vval);
    chk("R8 other slave silent", voe, 0);
    chk("R8 other slave sets no isr", int_out, 1);

    wr(3'd6, 8'hFF); idle(2);
    chk("R12 unknown code ignored", int_out, 1);
    irq_in = 8'h00; idle(3);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule